// File: doc/BRIEF.md
# Cascaded Display Timing Wave Generator

This block holds a bank of programmable counters that together build the timing waveforms of a video frame: an internal line tick, the horizontal and vertical sync pulses, a line-active window and a pixel-active window. Each counter steps on a source that software picks: nothing, the pixel clock enable, or the end-of-period pulse of another counter in the bank. This lets one counter count pixels into lines, the next count lines into frames, and further ones open windows inside them.

Each counter has a period length, a start delay counted on its own delay source, and a repeat limit. A limit of zero means the counter runs without end. A counter that has used up its repeats waits until a pulse from its chosen clear source sends it back to its delay phase. A counter can also shape its output into a level. The rising and falling positions are given in half-pixel units and are measured from the last end-of-period pulse on a separately chosen trigger source. Every output pin can be inverted on its own. Software programs the bank through a plain write port while the bank is disabled, then raises `enable`, and all counters start together.

Top module: `sync_wave_bank`

## Requirements
- R1: Source selects are 4 bits wide. Value 0 gives no ticks. Value 1 gives a tick on every cycle where `pix_tick` is high. A value k from 2 to NUM_GEN+1 gives a tick in each cycle after the cycle in which counter k-2 (zero-based) shows its end-of-period pulse. Larger values give no ticks.
- R2: Counting edges from the first clock edge at which `enable` is high (edge 0), with its run and delay sources set to 1 and `pix_tick` held high, a counter with run length R and delay D shows its first end-of-period pulse in the cycle after edge D+R+1. It then shows one every R+1 edges, and each pulse is one cycle wide.
- R3: The delay D counts ticks of the delay source. While that source is silent the counter stays in its delay phase and never pulses.
- R4: A repeat limit of 0 lets the counter run without end. A nonzero limit N stops the counter after exactly N pulses.
- R5: A stopped counter stays silent until a tick arrives from its clear source. That tick returns it to the delay phase with its delay and repeat state cleared, and the full delay-then-run sequence starts again.
- R6: With shaping on, the pin is high while 2·t lies in [rise, fall), where t is the number of trigger-source ticks since the counter's last end-of-period pulse. t is 0 in the cycle that shows the pulse. Before the first pulse the pin is low.
- R7: Invert-mask bit g flips output pin g. A pin whose counter is idle then sits high.
- R8: The write address is {counter index, word[1:0]}. Word 0 holds run length [11:0] and delay [27:16]. Word 1 holds repeat limit [11:0], run source [15:12], delay source [19:16], clear source [23:20], trigger source [27:24] and shaping enable [31]. Word 2 holds rise [9:0] and fall [25:16]. Word 3, at any index, holds the invert mask [NUM_GEN-1:0]. A write on an edge where `enable` is high is dropped.
- R9: While `enable` is low every counter is held in its delay phase with no pulse, so raising `enable` starts all counters from the same edge.
- R10: After reset all configuration and the invert mask are zero and every output pin is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Runs the counters; low holds them and opens the write port |
| pix_tick | input | 1 | Pixel clock enable, source value 1 |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_addr | input | $clog2(NUM_GEN)+2 | Counter index and word select |
| cfg_wr_data | input | 32 | Write data |
| wave_o | output | NUM_GEN | One timing pin per counter |

## Verification
The hardest state to reach from the ports is a counter that has used up its repeats and is then revived by a pulse that two other counters produce: a line counter stepping a frame counter. The bench builds exactly that three-stage chain, a line tick, a frame counter and a repeat-limited window that the frame clears. It then checks the window's pulse positions, cycle by cycle, across three frames. This covers the one-cycle lag at every stage, the silence while the window is stopped, and the restart that runs the delay phase again.

// File: rtl/sync_wave_pkg.sv
package sync_wave_pkg;
  localparam int CNT_W  = 12;
  localparam int EDGE_W = 10;
  localparam int SRC_W  = 4;
  localparam int DATA_W = 32;
  localparam int POS_W  = EDGE_W + 1;

  typedef enum logic [1:0] {
    PH_DELAY = 2'd0,
    PH_RUN   = 2'd1,
    PH_STOP  = 2'd2
  } phase_e;

  typedef struct packed {
    logic [CNT_W-1:0]  run_len;
    logic [CNT_W-1:0]  delay;
    logic [CNT_W-1:0]  reps;
    logic [SRC_W-1:0]  run_sel;
    logic [SRC_W-1:0]  delay_sel;
    logic [SRC_W-1:0]  clr_sel;
    logic [SRC_W-1:0]  trig_sel;
    logic              shape_en;
    logic [EDGE_W-1:0] rise_pos;
    logic [EDGE_W-1:0] fall_pos;
  } gen_cfg_t;
endpackage

// File: rtl/swb_cfg_regs.sv
module swb_cfg_regs
  import sync_wave_pkg::*;
#(
  parameter int NUM_GEN = 5,
  parameter int ADDR_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output gen_cfg_t          cfg_o [NUM_GEN],
  output logic [NUM_GEN-1:0] inv_o
);
  localparam int IDX_W = ADDR_W - 2;

  gen_cfg_t           cfg_q [NUM_GEN];
  logic [NUM_GEN-1:0] inv_q;
  logic               wr_ok;
  logic [1:0]         word;
  logic [IDX_W-1:0]   idx;
  logic               unused_bits;

  assign wr_ok       = wr_en && !enable;
  assign word        = wr_addr[1:0];
  assign idx         = wr_addr[ADDR_W-1:2];
  assign unused_bits = ^wr_data[30:28];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int g = 0; g < NUM_GEN; g++) cfg_q[g] <= '0;
      inv_q <= '0;
    end else if (wr_ok) begin
      if (word == 2'd3) inv_q <= wr_data[NUM_GEN-1:0];
      for (int g = 0; g < NUM_GEN; g++) begin
        if (idx == IDX_W'(g)) begin
          case (word)
            2'd0: begin
              cfg_q[g].run_len <= wr_data[CNT_W-1:0];
              cfg_q[g].delay   <= wr_data[16 +: CNT_W];
            end
            2'd1: begin
              cfg_q[g].reps      <= wr_data[CNT_W-1:0];
              cfg_q[g].run_sel   <= wr_data[12 +: SRC_W];
              cfg_q[g].delay_sel <= wr_data[16 +: SRC_W];
              cfg_q[g].clr_sel   <= wr_data[20 +: SRC_W];
              cfg_q[g].trig_sel  <= wr_data[24 +: SRC_W];
              cfg_q[g].shape_en  <= wr_data[31];
            end
            2'd2: begin
              cfg_q[g].rise_pos <= wr_data[EDGE_W-1:0];
              cfg_q[g].fall_pos <= wr_data[16 +: EDGE_W];
            end
            default: ;
          endcase
        end
      end
    end
  end

  assign cfg_o = cfg_q;
  assign inv_o = inv_q;

  assert_cfg_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    enable |=> ($stable(inv_q) && $stable(cfg_q[0]) && $stable(cfg_q[NUM_GEN-1])));
endmodule

// File: rtl/swb_src_mux.sv
module swb_src_mux
  import sync_wave_pkg::*;
#(
  parameter int NUM_GEN = 5
) (
  input  logic [SRC_W-1:0]   sel,
  input  logic               pix_tick,
  input  logic [NUM_GEN-1:0] pulses,
  output logic               tick
);
  always_comb begin
    tick = 1'b0;
    if (sel == SRC_W'(1)) tick = pix_tick;
    for (int k = 0; k < NUM_GEN; k++) begin
      if (sel == SRC_W'(k + 2)) tick = pulses[k];
    end
  end
endmodule

// File: rtl/swb_wave_counter.sv
module swb_wave_counter
  import sync_wave_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [CNT_W-1:0]  run_len,
  input  logic [CNT_W-1:0]  delay,
  input  logic [CNT_W-1:0]  reps,
  input  logic [EDGE_W-1:0] rise_pos,
  input  logic [EDGE_W-1:0] fall_pos,
  input  logic              run_tick,
  input  logic              delay_tick,
  input  logic              clr_tick,
  input  logic              trig_tick,
  output logic              pulse_o,
  output logic              level_o
);
  localparam logic [POS_W-1:0] POS_SAT = POS_W'(1) << EDGE_W;

  phase_e           phase_q;
  logic [CNT_W-1:0] run_cnt_q;
  logic [CNT_W-1:0] dly_cnt_q;
  logic [CNT_W-1:0] rep_cnt_q;
  logic             pulse_q;
  logic [POS_W-1:0] pos_q;
  logic             period_end;
  logic             last_rep;

  assign period_end = (phase_q == PH_RUN) && run_tick && (run_cnt_q == run_len);
  assign last_rep   = (reps != '0) && (({1'b0, rep_cnt_q} + 1'b1) == {1'b0, reps});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= PH_DELAY;
      run_cnt_q <= '0;
      dly_cnt_q <= '0;
      rep_cnt_q <= '0;
      pulse_q   <= 1'b0;
    end else if (!enable) begin
      phase_q   <= PH_DELAY;
      run_cnt_q <= '0;
      dly_cnt_q <= '0;
      rep_cnt_q <= '0;
      pulse_q   <= 1'b0;
    end else begin
      pulse_q <= period_end;
      case (phase_q)
        PH_DELAY: begin
          if (dly_cnt_q == delay) begin
            phase_q   <= PH_RUN;
            run_cnt_q <= '0;
          end else if (delay_tick) begin
            dly_cnt_q <= dly_cnt_q + 1'b1;
          end
        end
        PH_RUN: begin
          if (run_tick) begin
            if (run_cnt_q == run_len) begin
              run_cnt_q <= '0;
              if (reps != '0) rep_cnt_q <= rep_cnt_q + 1'b1;
              if (last_rep) phase_q <= PH_STOP;
            end else begin
              run_cnt_q <= run_cnt_q + 1'b1;
            end
          end
        end
        PH_STOP: begin
          if (clr_tick) begin
            phase_q   <= PH_DELAY;
            dly_cnt_q <= '0;
            rep_cnt_q <= '0;
            run_cnt_q <= '0;
          end
        end
        default: phase_q <= PH_DELAY;
      endcase
    end
  end

  // Edge position in half-pixel units since the last period end.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          pos_q <= POS_SAT;
    else if (!enable)                    pos_q <= POS_SAT;
    else if (period_end)                 pos_q <= '0;
    else if (trig_tick && pos_q < POS_SAT) pos_q <= pos_q + POS_W'(2);
  end

  assign pulse_o = pulse_q;
  assign level_o = (pos_q >= {1'b0, rise_pos}) && (pos_q < {1'b0, fall_pos});

  assert_run_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_RUN) |-> (run_cnt_q <= run_len));

  assert_pulse_origin_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |-> ($past(phase_q) == PH_RUN));

  assert_repeat_cap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reps != '0) |-> (rep_cnt_q <= reps));

  assert_stop_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && phase_q == PH_STOP && !clr_tick) |=> (phase_q == PH_STOP));

  assert_disable_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (phase_q == PH_DELAY && !pulse_q));
endmodule

// File: rtl/sync_wave_bank.sv
module sync_wave_bank
  import sync_wave_pkg::*;
#(
  parameter int NUM_GEN = 5,
  localparam int ADDR_W = $clog2(NUM_GEN) + 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic               pix_tick,
  input  logic               cfg_wr_en,
  input  logic [ADDR_W-1:0]  cfg_wr_addr,
  input  logic [31:0]        cfg_wr_data,
  output logic [NUM_GEN-1:0] wave_o
);
  gen_cfg_t           cfg [NUM_GEN];
  logic [NUM_GEN-1:0] inv;
  logic [NUM_GEN-1:0] pulse;
  logic [NUM_GEN-1:0] level;

  swb_cfg_regs #(.NUM_GEN(NUM_GEN), .ADDR_W(ADDR_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .enable  (enable),
    .wr_en   (cfg_wr_en),
    .wr_addr (cfg_wr_addr),
    .wr_data (cfg_wr_data),
    .cfg_o   (cfg),
    .inv_o   (inv)
  );

  for (genvar g = 0; g < NUM_GEN; g++) begin : g_gen
    logic run_tick, delay_tick, clr_tick, trig_tick;

    swb_src_mux #(.NUM_GEN(NUM_GEN)) u_run_mux (
      .sel(cfg[g].run_sel), .pix_tick(pix_tick), .pulses(pulse), .tick(run_tick));
    swb_src_mux #(.NUM_GEN(NUM_GEN)) u_dly_mux (
      .sel(cfg[g].delay_sel), .pix_tick(pix_tick), .pulses(pulse), .tick(delay_tick));
    swb_src_mux #(.NUM_GEN(NUM_GEN)) u_clr_mux (
      .sel(cfg[g].clr_sel), .pix_tick(pix_tick), .pulses(pulse), .tick(clr_tick));
    swb_src_mux #(.NUM_GEN(NUM_GEN)) u_trg_mux (
      .sel(cfg[g].trig_sel), .pix_tick(pix_tick), .pulses(pulse), .tick(trig_tick));

    swb_wave_counter u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .enable     (enable),
      .run_len    (cfg[g].run_len),
      .delay      (cfg[g].delay),
      .reps       (cfg[g].reps),
      .rise_pos   (cfg[g].rise_pos),
      .fall_pos   (cfg[g].fall_pos),
      .run_tick   (run_tick),
      .delay_tick (delay_tick),
      .clr_tick   (clr_tick),
      .trig_tick  (trig_tick),
      .pulse_o    (pulse[g]),
      .level_o    (level[g])
    );

    assign wave_o[g] = (cfg[g].shape_en ? level[g] : pulse[g]) ^ inv[g];
  end
endmodule

// File: tb/sync_wave_bank_tb_top.sv
module sync_wave_bank_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NG = 5;
  localparam int AW = $clog2(NG) + 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          enable = 1'b0;
  logic          pix_tick = 1'b1;
  logic          cfg_wr_en = 1'b0;
  logic [AW-1:0] cfg_wr_addr = '0;
  logic [31:0]   cfg_wr_data = '0;
  logic [NG-1:0] wave_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [63:0] seen [NG];

  always #(CLK_PERIOD/2) clk = ~clk;

  sync_wave_bank #(.NUM_GEN(NG)) dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .pix_tick(pix_tick),
    .cfg_wr_en(cfg_wr_en), .cfg_wr_addr(cfg_wr_addr),
    .cfg_wr_data(cfg_wr_data), .wave_o(wave_o)
  );

  typedef struct packed {
    logic [11:0] run_len;
    logic [11:0] delay;
    logic [11:0] reps;
    logic [7:0]  win;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{run_len: 12'd3, delay: 12'd0, reps: 12'd0, win: 8'd30},
    '{run_len: 12'd0, delay: 12'd0, reps: 12'd0, win: 8'd10},
    '{run_len: 12'd5, delay: 12'd4, reps: 12'd0, win: 8'd40},
    '{run_len: 12'd2, delay: 12'd0, reps: 12'd3, win: 8'd40},
    '{run_len: 12'd7, delay: 12'd2, reps: 12'd1, win: 8'd30},
    '{run_len: 12'd4, delay: 12'd3, reps: 12'd2, win: 8'd12}
  };

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input int g, input int w, input logic [31:0] d);
    cfg_wr_en   = 1'b1;
    cfg_wr_addr = AW'(g * 4 + w);
    cfg_wr_data = d;
    @(posedge clk);
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic setup(input int g, input int run_len, input int delay, input int reps,
                       input int rsel, input int dsel, input int csel, input int tsel,
                       input bit shape, input int rise, input int fall);
    wr(g, 0, (32'(delay) << 16) | 32'(run_len));
    wr(g, 1, (32'(shape) << 31) | (32'(tsel) << 24) | (32'(csel) << 20) |
             (32'(dsel) << 16) | (32'(rsel) << 12) | 32'(reps));
    wr(g, 2, (32'(fall) << 16) | 32'(rise));
  endtask

  task automatic clear_all();
    for (int g = 0; g < NG; g++) setup(g, 0, 0, 0, 0, 0, 0, 0, 1'b0, 0, 0);
    wr(0, 3, 32'd0);
  endtask

  // Raise enable, then sample every pin after each of n edges.
  task automatic run_window(input int n);
    for (int g = 0; g < NG; g++) seen[g] = '0;
    enable = 1'b1;
    for (int c = 0; c < n; c++) begin
      @(posedge clk);
      @(negedge clk);
      for (int g = 0; g < NG; g++) seen[g][c] = wave_o[g];
    end
  endtask

  task automatic stop_run();
    enable = 1'b0;
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [63:0] exp_mask(input int run_len, input int delay,
                                           input int reps, input int win);
    logic [63:0] m = '0;
    int e = delay + run_len + 1;
    int k = 0;
    while (e < win && (reps == 0 || k < reps)) begin
      m[e] = 1'b1;
      e += run_len + 1;
      k++;
    end
    return m;
  endfunction

  function automatic int first_one(input logic [63:0] m);
    for (int i = 0; i < 64; i++) if (m[i]) return i;
    return -1;
  endfunction

  initial begin
    #(CLK_PERIOD * 100000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [63:0] m;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 reset outputs low", 64'(wave_o), 64'd0);

    // Table: single counter on the pixel tick (R2, R3, R4, R9).
    for (int v = 0; v < 6; v++) begin
      clear_all();
      setup(0, int'(VECS[v].run_len), int'(VECS[v].delay), int'(VECS[v].reps),
            1, 1, 0, 0, 1'b0, 0, 0);
      run_window(int'(VECS[v].win));
      m = exp_mask(int'(VECS[v].run_len), int'(VECS[v].delay),
                   int'(VECS[v].reps), int'(VECS[v].win));
      check("R2 R9 pulse positions", seen[0], m);
      check("R3 R4 first pulse", 64'(first_one(seen[0])), 64'(first_one(m)));
      stop_run();
    end

    // R1: source 0 never ticks.
    clear_all();
    setup(0, 1, 0, 0, 0, 1, 0, 0, 1'b0, 0, 0);
    run_window(20);
    check("R1 source none", seen[0], 64'd0);
    stop_run();

    // R1 R3: silent pixel tick keeps counter idle.
    setup(0, 1, 0, 0, 1, 1, 0, 0, 1'b0, 0, 0);
    pix_tick = 1'b0;
    run_window(20);
    check("R1 R3 pixel tick low", seen[0], 64'd0);
    stop_run();
    pix_tick = 1'b1;

    // R1 R5: line tick -> frame counter clears a repeat-limited window.
    clear_all();
    setup(0, 3, 0, 0, 1, 1, 0, 0, 1'b0, 0, 0);
    setup(1, 0, 1, 2, 2, 2, 4, 0, 1'b0, 0, 0);
    setup(2, 5, 0, 0, 2, 2, 0, 0, 1'b0, 0, 0);
    run_window(64);
    m = '0;
    m[9] = 1'b1; m[13] = 1'b1; m[33] = 1'b1; m[37] = 1'b1; m[57] = 1'b1; m[61] = 1'b1;
    check("R5 window restart after clear", seen[1], m);
    m = '0;
    m[25] = 1'b1; m[49] = 1'b1;
    check("R1 chained frame counter", seen[2], m);
    stop_run();

    // R6: shaped level, rise 2 fall 8 half-pixels, period 10.
    clear_all();
    setup(0, 9, 0, 0, 1, 1, 0, 1, 1'b1, 2, 8);
    run_window(25);
    m = '0;
    m[11] = 1'b1; m[12] = 1'b1; m[13] = 1'b1;
    m[21] = 1'b1; m[22] = 1'b1; m[23] = 1'b1;
    check("R6 shaped level", seen[0], m);
    stop_run();

    // R7: invert pin 0 only.
    wr(0, 3, 32'd1);
    check("R7 inverted idle pin", 64'(wave_o), 64'd1);
    run_window(25);
    check("R7 inverted shaped level", seen[0], ~m & ((64'd1 << 25) - 1));
    stop_run();

    // R8: write while enabled is dropped.
    clear_all();
    setup(0, 3, 0, 0, 1, 1, 0, 0, 1'b0, 0, 0);
    for (int g = 0; g < NG; g++) seen[g] = '0;
    enable = 1'b1;
    for (int c = 0; c < 32; c++) begin
      @(posedge clk);
      @(negedge clk);
      seen[0][c] = wave_o[0];
      if (c == 5) begin
        cfg_wr_en = 1'b1; cfg_wr_addr = AW'(0); cfg_wr_data = 32'd0;
      end else begin
        cfg_wr_en = 1'b0;
      end
    end
    check("R8 write while enabled ignored", seen[0], exp_mask(3, 0, 0, 32));
    stop_run();
    run_window(12);
    check("R8 R9 config kept after re-enable", seen[0], exp_mask(3, 0, 0, 12));
    stop_run();

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule